// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates 32-bit virtual addresses to physical addresses through a small fully associative table. Each table slot describes a pair of neighbouring virtual pages. One slot carries two physical frames, one for the even page and one for the odd page. The page size of a slot is set by a page mask, from 4 KiB upward. Each frame has its own valid, dirty, read-inhibit and execute-inhibit flags.

A lookup is offered with `req_vld` together with the virtual address, the current 8-bit address-space identifier and the access kind. Exactly one clock later, `rsp_vld` pulses and the registered result appears. The result holds the translated address, a write-permission flag and a 3-bit result code that tells the requester which fault, if any, to raise. Software refills slots through a write port that addresses one slot per cycle.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset, every slot is marked hardware-invalidated, `rsp_vld` is 0 and `rsp_code`, `rsp_pa` and `rsp_wr_ok` are 0. A lookup issued before any write returns code 2.
- R2: A slot matches when all three of these hold:
  - its global bit is set, or its stored identifier equals `req_asid`;
  - its tag equals `req_va` in every bit above the effective mask;
  - its hardware-invalidate bit is clear.
- R3: The effective mask is `wr_pmask` ORed with 0x1FFF. The even/odd frame is chosen by the address bit at the highest set position of the effective mask: 0 selects even and 1 selects odd.
- R4: On code 0, `rsp_pa` is the selected frame ORed with the address bits below the selector bit.
- R5: A matching slot is checked in a fixed order against the selected frame's flags. The flag field is {xi[3], ri[2], dirty[1], valid[0]}. Access kinds are 0 fetch, 1 load and 2 store; kind 3 is treated as a load.
  - valid clear gives code 3;
  - a fetch with xi set gives code 6;
  - a load with ri set gives code 5;
  - a store with dirty clear gives code 4;
  - otherwise the code is 0.
  Code 1 is never produced.
- R6: `rsp_wr_ok` is 1 only when the code is 0 and the selected frame's dirty bit is set. A successful store therefore always has `rsp_wr_ok` set.
- R7: When no slot matches, the code is 2, `rsp_pa` is 0 and `rsp_wr_ok` is 0. Any non-zero code also forces `rsp_pa` to 0.
- R8: When several slots match, the one with the lowest index decides the result.
- R9: `rsp_vld` is high exactly in the cycle after `req_vld` was high. In cycles without a response, the result outputs keep their last values.
- R10: A slot write takes effect at the clock edge that samples it. A lookup sampled at the same edge sees the slot's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one slot this cycle |
| wr_idx | input | IDX_W | Slot index to write |
| wr_tag | input | ADDR_W | Virtual tag of the page pair |
| wr_asid | input | ASID_W | Address-space identifier of the slot |
| wr_global | input | 1 | Slot matches any identifier |
| wr_hinv | input | 1 | Slot is hardware-invalidated and never matches |
| wr_pmask | input | ADDR_W | Page mask (bits above 12) |
| wr_pfn_even | input | ADDR_W | Physical frame for the even page |
| wr_flags_even | input | 4 | {xi, ri, dirty, valid} of the even page |
| wr_pfn_odd | input | ADDR_W | Physical frame for the odd page |
| wr_flags_odd | input | 4 | {xi, ri, dirty, valid} of the odd page |
| req_vld | input | 1 | Lookup request strobe |
| req_va | input | ADDR_W | Virtual address to translate |
| req_asid | input | ASID_W | Current address-space identifier |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| rsp_vld | output | 1 | Result valid, one cycle after the request |
| rsp_pa | output | ADDR_W | Translated physical address |
| rsp_wr_ok | output | 1 | Writes permitted to the page |
| rsp_code | output | 3 | Result code magnitude (0, 2..6) |

## Verification
The properties assume that `req_vld` stays low while reset is asserted, so the first response cycle after reset has a clean history. The address arithmetic takes two things for granted:
- every page mask is a contiguous run of ones starting at bit 13;
- every frame number is aligned to its page size.

Under those conditions, ORing the frame with the offset equals adding it, and the top mask bit is the pair selector. The stimulus writes only such masks: 4 KiB, 16 KiB and 16 MiB pages, with frames aligned to match. The reference model in the bench locates the selector by scanning for the highest mask bit rather than by the shift identity, so a mask the stimulus got wrong would show up as a mismatch.

// File: rtl/tlb_pair_lookup.sv
`timescale 1ns/1ps
module tlb_pair_lookup #(
  parameter int NUM_ENT = 16,
  parameter int ADDR_W  = 32,
  parameter int ASID_W  = 8,
  parameter int MIN_PG  = 12,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_hinv,
  input  logic [ADDR_W-1:0] wr_pmask,
  input  logic [ADDR_W-1:0] wr_pfn_even,
  input  logic [3:0]        wr_flags_even,
  input  logic [ADDR_W-1:0] wr_pfn_odd,
  input  logic [3:0]        wr_flags_odd,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [1:0]        req_kind,
  output logic              rsp_vld,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_wr_ok,
  output logic [2:0]        rsp_code
);
  localparam logic [ADDR_W-1:0] MIN_MASK = {{(ADDR_W-MIN_PG-1){1'b0}}, {(MIN_PG+1){1'b1}}};
  localparam int FL_V = 0, FL_D = 1, FL_RI = 2, FL_XI = 3;
  localparam logic [1:0] K_FETCH = 2'd0, K_STORE = 2'd2;
  localparam logic [2:0] C_OK = 3'd0, C_MISS = 3'd2, C_INV = 3'd3,
                         C_DIRTY = 3'd4, C_RI = 3'd5, C_XI = 3'd6;

  logic [ADDR_W-1:0] e_tag  [NUM_ENT];
  logic [ADDR_W-1:0] e_pmask[NUM_ENT];
  logic [ADDR_W-1:0] e_pfn0 [NUM_ENT];
  logic [ADDR_W-1:0] e_pfn1 [NUM_ENT];
  logic [ASID_W-1:0] e_asid [NUM_ENT];
  logic [3:0]        e_fl0  [NUM_ENT];
  logic [3:0]        e_fl1  [NUM_ENT];
  logic [NUM_ENT-1:0] e_glb, e_hinv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        e_tag[i]   <= '0;
        e_pmask[i] <= '0;
        e_pfn0[i]  <= '0;
        e_pfn1[i]  <= '0;
        e_asid[i]  <= '0;
        e_fl0[i]   <= '0;
        e_fl1[i]   <= '0;
      end
      e_glb  <= '0;
      e_hinv <= '1;
    end else if (wr_en) begin
      e_tag[wr_idx]   <= wr_tag;
      e_pmask[wr_idx] <= wr_pmask;
      e_pfn0[wr_idx]  <= wr_pfn_even;
      e_pfn1[wr_idx]  <= wr_pfn_odd;
      e_asid[wr_idx]  <= wr_asid;
      e_fl0[wr_idx]   <= wr_flags_even;
      e_fl1[wr_idx]   <= wr_flags_odd;
      e_glb[wr_idx]   <= wr_global;
      e_hinv[wr_idx]  <= wr_hinv;
    end
  end

  logic [NUM_ENT-1:0] hit, odd;
  logic [ADDR_W-1:0]  half_m [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [ADDR_W-1:0] em;
    assign em        = e_pmask[g] | MIN_MASK;
    assign half_m[g] = em >> 1;
    assign hit[g]    = (e_glb[g] || e_asid[g] == req_asid) && !e_hinv[g] &&
                       ((e_tag[g] & ~em) == (req_va & ~em));
    assign odd[g]    = |(req_va & em & ~half_m[g]);
  end

  logic             found;
  logic [IDX_W-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (hit[i]) begin
        found = 1'b1;
        sel   = i[IDX_W-1:0];
      end
  end

  logic [3:0]        s_fl;
  logic [ADDR_W-1:0] s_pa;
  logic [2:0]        n_code;

  assign s_fl = odd[sel] ? e_fl1[sel] : e_fl0[sel];
  assign s_pa = (odd[sel] ? e_pfn1[sel] : e_pfn0[sel]) | (req_va & half_m[sel]);

  always_comb begin
    if (!found)                                   n_code = C_MISS;
    else if (!s_fl[FL_V])                         n_code = C_INV;
    else if (req_kind == K_FETCH && s_fl[FL_XI])  n_code = C_XI;
    else if (req_kind != K_FETCH && req_kind != K_STORE && s_fl[FL_RI])
                                                  n_code = C_RI;
    else if (req_kind == K_STORE && !s_fl[FL_D])  n_code = C_DIRTY;
    else                                          n_code = C_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_pa    <= '0;
      rsp_wr_ok <= 1'b0;
      rsp_code  <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_code  <= n_code;
        rsp_pa    <= (n_code == C_OK) ? s_pa : '0;
        rsp_wr_ok <= (n_code == C_OK) && s_fl[FL_D];
      end
    end
  end
endmodule

// File: rtl/tlb_pair_lookup_chk.sv
`timescale 1ns/1ps
module tlb_pair_lookup_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [1:0]        req_kind,
  input logic              rsp_vld,
  input logic [ADDR_W-1:0] rsp_pa,
  input logic              rsp_wr_ok,
  input logic [2:0]        rsp_code
);
  // R9
  rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> $stable(rsp_code) && $stable(rsp_pa) && $stable(rsp_wr_ok));
  // R5
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (rsp_code != 3'd1 && rsp_code != 3'd7));
  // R6
  wr_ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_ok |-> rsp_code == 3'd0);
  // R7
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_code != 3'd0) |-> (rsp_pa == '0 && !rsp_wr_ok));
  // R6
  store_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_code == 3'd0 && $past(req_kind) == 2'd2) |-> rsp_wr_ok);
endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
  .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_wr_ok(rsp_wr_ok), .rsp_code(rsp_code)
);

// File: tb/tlb_pair_lookup_tb.sv
`timescale 1ns/1ps
module tlb_pair_lookup_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_en = 0, wr_global = 0, wr_hinv = 0, req_vld = 0;
  logic [3:0]  wr_idx = 0, wr_flags_even = 0, wr_flags_odd = 0;
  logic [31:0] wr_tag = 0, wr_pmask = 0, wr_pfn_even = 0, wr_pfn_odd = 0, req_va = 0;
  logic [7:0]  wr_asid = 0, req_asid = 0;
  logic [1:0]  req_kind = 0;
  logic        rsp_vld, rsp_wr_ok;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_code;

  tlb_pair_lookup u_dut (.*);

  bit [31:0] m_tag[16], m_pm[16], m_pfn0[16], m_pfn1[16];
  bit [7:0]  m_asid[16];
  bit        m_glb[16], m_hinv[16];
  bit [3:0]  m_f0[16], m_f1[16];

  int checks = 0, fails = 0;
  int e_code = 0;
  bit [31:0] e_pa = 0;
  bit e_wok = 0, e_vld = 0;
  string cur_req = "R1";

  function automatic void ref_lookup(input bit [31:0] va, input bit [7:0] as, input int kind,
                                     output int code, output bit [31:0] pa, output bit wok);
    bit [31:0] em;
    int top;
    bit [3:0] f;
    bit [31:0] pfn;
    code = 2; pa = 0; wok = 0;
    for (int i = 0; i < 16; i++) begin
      em = m_pm[i] | 32'h1FFF;
      top = 0;
      for (int b = 0; b < 32; b++) if (em[b]) top = b;
      if (m_hinv[i] || !(m_glb[i] || m_asid[i] == as)) continue;
      if (((va ^ m_tag[i]) & ~em) != 0) continue;
      f   = va[top] ? m_f1[i] : m_f0[i];
      pfn = va[top] ? m_pfn1[i] : m_pfn0[i];
      if (!f[0]) code = 3;
      else if (kind == 0 && f[3]) code = 6;
      else if (kind == 1 && f[2]) code = 5;
      else if (kind == 2 && !f[1]) code = 4;
      else begin
        code = 0;
        pa = pfn | (va & ((32'h1 << top) - 1));
        wok = f[1];
      end
      return;
    end
  endfunction

  task automatic cycle();
    if (req_vld) ref_lookup(req_va, req_asid, int'(req_kind), e_code, e_pa, e_wok);
    e_vld = req_vld;
    if (wr_en) begin
      m_tag[wr_idx] = wr_tag; m_pm[wr_idx] = wr_pmask; m_asid[wr_idx] = wr_asid;
      m_glb[wr_idx] = wr_global; m_hinv[wr_idx] = wr_hinv;
      m_pfn0[wr_idx] = wr_pfn_even; m_f0[wr_idx] = wr_flags_even;
      m_pfn1[wr_idx] = wr_pfn_odd; m_f1[wr_idx] = wr_flags_odd;
    end
    @(negedge clk);
    checks++;
    if (rsp_vld !== e_vld || int'(rsp_code) != e_code || rsp_pa !== e_pa || rsp_wr_ok !== e_wok) begin
      fails++;
      $display("FAIL %s: vld/code/pa/wr_ok got %0b/%0d/%h/%0b exp %0b/%0d/%h/%0b",
               cur_req, rsp_vld, rsp_code, rsp_pa, rsp_wr_ok, e_vld, e_code, e_pa, e_wok);
    end
    wr_en = 0;
    req_vld = 0;
  endtask

  task automatic put(input int idx, input bit [31:0] tag, input bit [7:0] as, input bit glb,
                     input bit hinv, input bit [31:0] pm, input bit [31:0] p0, input bit [3:0] f0,
                     input bit [31:0] p1, input bit [3:0] f1);
    wr_en = 1; wr_idx = idx[3:0]; wr_tag = tag; wr_asid = as; wr_global = glb; wr_hinv = hinv;
    wr_pmask = pm; wr_pfn_even = p0; wr_flags_even = f0; wr_pfn_odd = p1; wr_flags_odd = f1;
  endtask

  task automatic look(input bit [31:0] va, input bit [7:0] as, input bit [1:0] kind, input string r);
    req_vld = 1; req_va = va; req_asid = as; req_kind = kind; cur_req = r;
    cycle();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_hinv[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; cycle();                       // reset state
    look(32'h0000_0000, 8'd0, 2'd1, "R1");         // empty table -> miss
    cur_req = "R9"; cycle();                       // idle, outputs hold
    // R10: write and same-cycle lookup sees old contents
    put(3, 32'h0040_0000, 8'd5, 0, 0, 32'h0, 32'h1000_0000, 4'b0011, 32'h2000_0000, 4'b0001);
    look(32'h0040_0123, 8'd5, 2'd2, "R10");
    look(32'h0040_0123, 8'd5, 2'd2, "R4");         // even store ok
    look(32'h0040_1ABC, 8'd5, 2'd1, "R3");         // bit12 -> odd frame
    look(32'h0040_1ABC, 8'd5, 2'd2, "R6");         // odd dirty clear -> code 4
    look(32'h0040_0123, 8'd6, 2'd1, "R2");         // wrong identifier
    look(32'h0040_2123, 8'd5, 2'd1, "R7");         // outside the pair
    // 16 KiB pages, global, odd page inhibited
    put(4, 32'h0100_0000, 8'd9, 1, 0, 32'h6000, 32'h0, 4'b0000, 32'h0500_0000, 4'b1101);
    cycle();
    look(32'h0100_4010, 8'd77, 2'd0, "R5");        // xi
    look(32'h0100_4010, 8'd1, 2'd1, "R5");         // ri
    look(32'h0100_4010, 8'd1, 2'd2, "R5");         // dirty clear
    look(32'h0100_3FFF, 8'd1, 2'd0, "R5");         // even invalid
    look(32'h0100_1000, 8'd1, 2'd2, "R3");         // bit12 inside even page
    put(5, 32'h0200_0000, 8'd0, 1, 0, 32'h6000, 32'h0, 4'b0000, 32'h0ABC_0000, 4'b0001);
    cycle();
    look(32'h0200_5678, 8'd3, 2'd1, "R4");
    look(32'h0200_5678, 8'd3, 2'd3, "R5");         // kind 3 behaves as load
    // R8: two matching slots, lowest index wins
    put(7, 32'h0300_0000, 8'd0, 1, 0, 32'h0, 32'h2200_0000, 4'b0011, 32'h0, 4'b0001);
    cycle();
    put(2, 32'h0300_0000, 8'd0, 1, 0, 32'h0, 32'h1100_0000, 4'b0001, 32'h0, 4'b0001);
    cycle();
    look(32'h0300_0444, 8'd0, 2'd1, "R8");
    look(32'h0300_0444, 8'd0, 2'd2, "R8");
    // R2: hardware-invalidate blocks a match
    put(8, 32'h0400_0000, 8'd0, 1, 1, 32'h0, 32'h3300_0000, 4'b0011, 32'h0, 4'b0011);
    cycle();
    look(32'h0400_0010, 8'd0, 2'd1, "R2");
    // 16 MiB pages
    put(9, 32'h4000_0000, 8'd4, 0, 0, 32'h01FF_E000, 32'h8000_0000, 4'b0011, 32'h9000_0000, 4'b0011);
    cycle();
    look(32'h40AB_CDEF, 8'd4, 2'd2, "R3");
    look(32'h41AB_CDEF, 8'd4, 2'd0, "R4");
    // invalidate slot 3 by overwrite
    put(3, 32'h0040_0000, 8'd5, 0, 1, 32'h0, 32'h1000_0000, 4'b0011, 32'h2000_0000, 4'b0001);
    cycle();
    look(32'h0040_0123, 8'd5, 2'd1, "R7");
    cur_req = "R9"; cycle();
    cycle();
    look(32'h0300_0444, 8'd9, 2'd0, "R9");
    look(32'h0200_5678, 8'd3, 2'd2, "R6");
    cur_req = "R9"; cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule